// File: doc/BRIEF.md
# Self-Clocking Single-Wire Manchester Receiver

This block decodes a single-wire serial stream that carries no separate clock. Each logical bit occupies one bit period split into two halves. A one is a high half followed by a low half. A zero is a low half followed by a high half. The direction of the mid-bit edge therefore gives the bit value. The line is oversampled by the fast system clock after a synchronizer. Because the receiver has no fixed baud rate, every frame opens with a preamble of eight ones. The receiver times four whole bit periods of that preamble and then holds the result as its bit period.

With the period learned, the receiver expects each mid-bit edge in a detection window centred half a period after the bit start, and re-centres on every edge it accepts. Bits are grouped MSB first into bytes that appear with a one-cycle valid strobe. The block also pulses at the end of the preamble and when the terminator byte 0x81 arrives. The terminator, a long low idle, or any framing fault discards the learned period. After a framing fault the receiver ignores the line until it sees an idle gap.

Top module: `mwire_rx`

## Requirements
- R1: While reset is applied and in the cycles after it, byte_valid, frame_start, frame_end and frame_err are low and byte_data is zero.
- R2: A high half then a low half decodes as 1, and a low half then a high half decodes as 0. The first data bit after the preamble lands in byte_data bit 7. After eight data bits the byte is presented with byte_valid high for exactly one cycle.
- R3: There is no configured rate. The bit period is one quarter of the number of clock cycles from the first rising edge of the preamble to the fifth. Frames with bit periods of 50, 100 and 200 clock cycles all decode with the default parameters.
- R4: The preamble is eight 1 bits. frame_start pulses for one cycle when the eighth is decoded. A 0 decoded in preamble bits five to eight raises frame_err.
- R5: The byte 0x81 ends the frame. It produces a frame_end pulse and no byte_valid, and it discards the learned period. A new preamble at a different rate that follows straight after is accepted.
- R6: The mid-bit edge is accepted if it falls within plus or minus period>>WIN_SHIFT (a quarter period by default) of half a period after the bit start. If no edge has arrived when that window closes, frame_err pulses.
- R7: After frame_err, none of byte_valid, frame_start or frame_end is raised until the line has been low for IDLE_CYC cycles and a new preamble has been received.
- R8: A low level held for IDLE_CYC cycles discards any partial measurement or learned period. Learning then starts again at the next rising edge.
- R9: During measurement of the preamble, a high or low pulse shorter than MIN_PULSE_CYC cycles raises frame_err.
- R10: At most one of byte_valid, frame_start, frame_end and frame_err is high in any cycle.
- R11: After reset, no preamble is accepted until the line has been low for IDLE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the line |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 1 | Asynchronous single-wire serial input |
| byte_data | output | 8 | Last decoded byte, MSB received first |
| byte_valid | output | 1 | One-cycle strobe: byte_data holds a new byte |
| frame_start | output | 1 | One-cycle strobe: preamble completed |
| frame_end | output | 1 | One-cycle strobe: terminator received |
| frame_err | output | 1 | One-cycle strobe: framing fault, frame dropped |

## Verification
The bench sends frames at three rates back to back, with no idle between a terminator and the next preamble. A receiver that kept its old period would then misplace every window of the next frame. Mid-bit edges are moved by a few cycles in both directions, and one edge is pushed outside the window. A window placed off centre would either reject the jittered frame or accept the bad edge. The bench also injects a short glitch inside the preamble, a zero in the preamble tail, and a partial preamble followed by idle. Each of these must give exactly one error or a clean restart. Traffic sent after a fault, and before the first idle after reset, must produce no strobes at all, so a receiver that resumes too early shows up as extra events.

// File: rtl/mwire_rx_pkg.sv
package mwire_rx_pkg;

   typedef enum logic [2:0] {
      ST_WAIT_IDLE,
      ST_HUNT,
      ST_MEASURE,
      ST_FRAME,
      ST_ERROR
   } rx_state_e;

   localparam logic [7:0] TERM_BYTE     = 8'h81;
   localparam int         MEAS_RISES    = 4;
   localparam int         PRE_TAIL_BITS = 4;

endpackage

// File: rtl/mwire_rx_sync.sv
module mwire_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              lvl_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("mwire_rx_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_flop
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= chain[STAGES-1];
   end

   assign lvl  = chain[STAGES-1];
   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/mwire_rx_runlen.sv
module mwire_rx_runlen #(
   parameter int IDLE_CYC = 1000,
   parameter int RW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lvl,
   input  logic          edge_seen,
   output logic [RW-1:0] run,
   output logic          idle
);
   if ((2 ** RW) <= IDLE_CYC) begin : g_bad_width
      $error("mwire_rx_runlen: RW too narrow for IDLE_CYC");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run <= '0;
      else if (edge_seen)       run <= RW'(1);
      else if (run != '1)       run <= run + 1'b1;
   end

   assign idle = ~lvl && (run >= RW'(IDLE_CYC));
endmodule

// File: rtl/mwire_rx_slicer.sv
module mwire_rx_slicer #(
   parameter int PW        = 9,
   parameter int WIN_SHIFT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          active,
   input  logic [PW-1:0] period,
   input  logic          rise,
   input  logic          fall,
   output logic          bit_stb,
   output logic          bit_val,
   output logic          err_stb
);
   logic [PW-1:0] t;
   logic          got;
   logic [PW-1:0] half, wq, win_lo, win_hi;
   logic          in_win;

   if (WIN_SHIFT < 2) begin : g_bad_win
      $error("mwire_rx_slicer: WIN_SHIFT below 2 lets windows overlap");
   end

   assign half   = period >> 1;
   assign wq     = period >> WIN_SHIFT;
   assign win_lo = half - wq;
   assign win_hi = half + wq;
   assign in_win = (t >= win_lo) && (t <= win_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t       <= '0;
         got     <= 1'b0;
         bit_stb <= 1'b0;
         bit_val <= 1'b0;
         err_stb <= 1'b0;
      end else begin
         bit_stb <= 1'b0;
         err_stb <= 1'b0;
         if (start) begin
            t   <= PW'(1);
            got <= 1'b0;
         end else if (active) begin
            if ((rise | fall) && in_win) begin
               if (got) begin
                  err_stb <= 1'b1;
               end else begin
                  got     <= 1'b1;
                  bit_stb <= 1'b1;
                  bit_val <= fall;
               end
               t <= half + 1'b1;
            end else begin
               if (!got && (t == win_hi)) err_stb <= 1'b1;
               if (t == period - 1'b1) begin
                  t   <= '0;
                  got <= 1'b0;
               end else begin
                  t <= t + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/mwire_rx.sv
module mwire_rx #(
   parameter int MAX_BIT_CYC   = 256,
   parameter int MIN_PULSE_CYC = 10,
   parameter int IDLE_CYC      = 1000,
   parameter int SYNC_STAGES   = 2,
   parameter int WIN_SHIFT     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   output logic [7:0] byte_data,
   output logic       byte_valid,
   output logic       frame_start,
   output logic       frame_end,
   output logic       frame_err
);
   import mwire_rx_pkg::*;

   localparam int PW = $clog2(MAX_BIT_CYC + 1);
   localparam int MW = PW + 2;
   localparam int RW = $clog2(IDLE_CYC + 1);

   if (IDLE_CYC <= MAX_BIT_CYC) begin : g_bad_idle
      $error("mwire_rx: IDLE_CYC must exceed the longest legal low level");
   end
   if (MIN_PULSE_CYC < 1 || 2 * MIN_PULSE_CYC > MAX_BIT_CYC) begin : g_bad_pulse
      $error("mwire_rx: MIN_PULSE_CYC out of range");
   end

   rx_state_e     state;
   logic          lvl, rise, fall, edge_seen, idle;
   logic [RW-1:0] run;
   logic [MW-1:0] cnt;
   logic [1:0]    rises;
   logic [2:0]    pre_left;
   logic [2:0]    nbits;
   logic [6:0]    shreg;
   logic [PW-1:0] period;
   logic          sl_bit, sl_val, sl_err;
   logic          short_pulse, cnt_full, meas_last, meas_done;
   logic [7:0]    next_byte;

   assign edge_seen = rise | fall;

   mwire_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(din),
      .lvl(lvl), .rise(rise), .fall(fall)
   );

   mwire_rx_runlen #(.IDLE_CYC(IDLE_CYC), .RW(RW)) u_runlen (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .edge_seen(edge_seen),
      .run(run), .idle(idle)
   );

   assign short_pulse = edge_seen && (run < RW'(MIN_PULSE_CYC));
   assign cnt_full    = (cnt == MW'(4 * MAX_BIT_CYC));
   assign meas_last   = rise && (rises == 2'(MEAS_RISES - 1));
   assign meas_done   = (state == ST_MEASURE) && !idle && !short_pulse
                        && meas_last && !cnt_full;
   assign next_byte   = {shreg, sl_val};

   mwire_rx_slicer #(.PW(PW), .WIN_SHIFT(WIN_SHIFT)) u_slicer (
      .clk(clk), .rst_n(rst_n),
      .start(meas_done), .active(state == ST_FRAME),
      .period(period), .rise(rise), .fall(fall),
      .bit_stb(sl_bit), .bit_val(sl_val), .err_stb(sl_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_WAIT_IDLE;
         cnt         <= '0;
         rises       <= '0;
         pre_left    <= '0;
         nbits       <= '0;
         shreg       <= '0;
         period      <= '0;
         byte_data   <= '0;
         byte_valid  <= 1'b0;
         frame_start <= 1'b0;
         frame_end   <= 1'b0;
         frame_err   <= 1'b0;
      end else begin
         byte_valid  <= 1'b0;
         frame_start <= 1'b0;
         frame_end   <= 1'b0;
         frame_err   <= 1'b0;
         if (idle && state != ST_HUNT) begin
            state  <= ST_HUNT;
            period <= '0;
         end else begin
            unique case (state)
               ST_WAIT_IDLE, ST_ERROR: ;
               ST_HUNT: if (rise) begin
                  state <= ST_MEASURE;
                  cnt   <= MW'(1);
                  rises <= '0;
               end
               ST_MEASURE: begin
                  if (!cnt_full) cnt <= cnt + 1'b1;
                  if (short_pulse || (meas_last && cnt_full)) begin
                     state     <= ST_ERROR;
                     frame_err <= 1'b1;
                  end else if (meas_last) begin
                     period   <= cnt[MW-1:2];
                     state    <= ST_FRAME;
                     pre_left <= 3'(PRE_TAIL_BITS);
                     nbits    <= '0;
                  end else if (rise) begin
                     rises <= rises + 1'b1;
                  end
               end
               ST_FRAME: begin
                  if (sl_err) begin
                     state     <= ST_ERROR;
                     frame_err <= 1'b1;
                     period    <= '0;
                  end else if (sl_bit) begin
                     if (pre_left != '0) begin
                        if (!sl_val) begin
                           state     <= ST_ERROR;
                           frame_err <= 1'b1;
                           period    <= '0;
                        end else begin
                           pre_left <= pre_left - 1'b1;
                           if (pre_left == 3'd1) frame_start <= 1'b1;
                        end
                     end else begin
                        shreg <= next_byte[6:0];
                        nbits <= nbits + 1'b1;
                        if (nbits == 3'd7) begin
                           if (next_byte == TERM_BYTE) begin
                              frame_end <= 1'b1;
                              state     <= ST_HUNT;
                              period    <= '0;
                           end else begin
                              byte_valid <= 1'b1;
                              byte_data  <= next_byte;
                           end
                        end
                     end
                  end
               end
               default: state <= ST_ERROR;
            endcase
         end
      end
   end
endmodule

// File: rtl/mwire_rx_chk.sv
module mwire_rx_chk #(
   parameter int IDLE_CYC = 1000
) (
   input logic clk,
   input logic rst_n,
   input logic din,
   input logic byte_valid,
   input logic frame_start,
   input logic frame_end,
   input logic frame_err
);
   localparam int QUIET_AT = IDLE_CYC + 8;
   int lowcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lowcnt <= 0;
      else if (din)              lowcnt <= 0;
      else if (lowcnt < QUIET_AT) lowcnt <= lowcnt + 1;
   end

   a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({byte_valid, frame_start, frame_end, frame_err}));

   a_r2_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

   a_r4_start_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (!frame_start && !byte_valid));

   a_r7_err_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !(byte_valid || frame_start || frame_end));

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (lowcnt >= QUIET_AT) |-> !(byte_valid || frame_start || frame_end || frame_err));
endmodule

bind mwire_rx mwire_rx_chk #(.IDLE_CYC(IDLE_CYC)) u_mwire_rx_chk (
   .clk(clk), .rst_n(rst_n), .din(din),
   .byte_valid(byte_valid), .frame_start(frame_start),
   .frame_end(frame_end), .frame_err(frame_err)
);

// File: tb/mwire_rx_bench.sv
module mwire_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       din = 1'b0;
   logic [7:0] byte_data;
   logic       byte_valid, frame_start, frame_end, frame_err;

   int    checks = 0;
   int    fails = 0;
   int    unexpected = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   // event kinds: 1 start, 2 byte, 3 end, 4 error
   int    exp_kind[$];
   int    exp_data[$];
   string exp_req[$];

   always #5 clk = ~clk;

   mwire_rx u_mwire_rx (
      .clk(clk), .rst_n(rst_n), .din(din), .byte_data(byte_data),
      .byte_valid(byte_valid), .frame_start(frame_start),
      .frame_end(frame_end), .frame_err(frame_err)
   );

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic expect_ev(input int k, input int d, input string r);
      exp_kind.push_back(k);
      exp_data.push_back(d);
      exp_req.push_back(r);
   endtask

   // reference comparison on every clock, away from the active edge
   always @(negedge clk) begin
      int n, k;
      if (rst_n && !done) begin
         n = int'(byte_valid) + int'(frame_start) + int'(frame_end) + int'(frame_err);
         if (n > 1) check(1'b0, "R10", "strobes in one cycle", n, 1);
         if (n >= 1) begin
            k = byte_valid ? 2 : frame_start ? 1 : frame_end ? 3 : 4;
            if (exp_kind.size() == 0) begin
               unexpected++;
               check(1'b0, "R7 R11", "unexpected event kind", k, 0);
            end else begin
               int    ek, ed;
               string er;
               ek = exp_kind.pop_front();
               ed = exp_data.pop_front();
               er = exp_req.pop_front();
               check(k == ek, er, "event kind", k, ek);
               if (k == 2 && ek == 2)
                  check(int'(byte_data) == ed, er, "byte value", int'(byte_data), ed);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         check(1'b0, "watchdog", "cycles", cyc, 190000);
         finish_run();
      end
   end

   task automatic hold(input logic v, input int n);
      din = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic v, input int p, input int jit);
      hold(v, p / 2 + jit);
      hold(~v, p - p / 2 - jit);
   endtask

   task automatic send_pre(input int p);
      for (int i = 0; i < 8; i++) send_bit(1'b1, p, 0);
   endtask

   task automatic send_byte(input logic [7:0] b, input int p, input int jit);
      for (int i = 7; i >= 0; i--) send_bit(b[i], p, (i % 2 == 1) ? jit : -jit);
   endtask

   task automatic wait_quiet(input int n);
      hold(1'b0, n);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(byte_valid == 0 && frame_start == 0 && frame_end == 0 && frame_err == 0
            && byte_data == 8'h00, "R1", "outputs during reset", int'(byte_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(byte_valid == 0 && frame_err == 0 && byte_data == 8'h00,
            "R1", "outputs after reset", int'(byte_data), 0);

      // R11: no idle seen yet, so this frame must be ignored
      send_pre(100);
      send_byte(8'h3C, 100, 0);
      wait_quiet(1200);
      check(unexpected == 0 && exp_kind.size() == 0, "R11", "events before first idle",
            unexpected, 0);

      // R2 R3 R4 R5: frame at 100-cycle bits
      expect_ev(1, 0, "R4"); expect_ev(2, 8'hA5, "R2"); expect_ev(2, 8'h00, "R2");
      expect_ev(2, 8'hFF, "R3"); expect_ev(3, 0, "R5");
      send_pre(100);
      send_byte(8'hA5, 100, 0); send_byte(8'h00, 100, 0); send_byte(8'hFF, 100, 0);
      send_byte(8'h81, 100, 0);

      // R5 R6: new rate straight after the terminator, with edge jitter
      expect_ev(1, 0, "R5"); expect_ev(2, 8'h12, "R6"); expect_ev(2, 8'h7E, "R6");
      expect_ev(3, 0, "R5");
      send_pre(50);
      send_byte(8'h12, 50, 5); send_byte(8'h7E, 50, 5); send_byte(8'h81, 50, 5);

      // R3: slowest rate
      expect_ev(1, 0, "R3"); expect_ev(2, 8'hC3, "R3"); expect_ev(3, 0, "R3");
      send_pre(200);
      send_byte(8'hC3, 200, -5); send_byte(8'h81, 200, 0);
      wait_quiet(1200);

      // R6 R7: mid edge beyond the window, rest of traffic ignored
      expect_ev(1, 0, "R6"); expect_ev(4, 0, "R6");
      send_pre(100);
      send_bit(1'b0, 100, 30);
      send_byte(8'h11, 100, 0); send_byte(8'h81, 100, 0);
      send_pre(100); send_byte(8'h22, 100, 0);
      wait_quiet(1200);
      check(unexpected == 0 && exp_kind.size() == 0, "R7", "events after error",
            unexpected, 0);

      // R9: glitch inside preamble
      expect_ev(4, 0, "R9");
      send_bit(1'b1, 100, 0);
      hold(1'b1, 20); hold(1'b0, 3); hold(1'b1, 27); hold(1'b0, 50);
      for (int i = 0; i < 6; i++) send_bit(1'b1, 100, 0);
      send_byte(8'h99, 100, 0); send_byte(8'h81, 100, 0);
      wait_quiet(1200);

      // R4: zero in the preamble tail
      expect_ev(4, 0, "R4");
      for (int i = 0; i < 5; i++) send_bit(1'b1, 100, 0);
      send_bit(1'b0, 100, 0); send_bit(1'b1, 100, 0); send_bit(1'b1, 100, 0);
      send_byte(8'h42, 100, 0); send_byte(8'h81, 100, 0);
      wait_quiet(1200);

      // R8: partial preamble then idle, measurement restarts
      for (int i = 0; i < 3; i++) send_bit(1'b1, 100, 0);
      wait_quiet(1200);
      expect_ev(1, 0, "R8"); expect_ev(2, 8'h69, "R8"); expect_ev(3, 0, "R8");
      send_pre(100);
      send_byte(8'h69, 100, 0); send_byte(8'h81, 100, 0);
      wait_quiet(300);

      check(exp_kind.size() == 0, "R2", "events still outstanding", exp_kind.size(), 0);
      check(unexpected == 0, "R7", "unexpected events total", unexpected, 0);
      finish_run();
   end
endmodule